// File: doc/BRIEF.md
# Tick-Synchronised Register Write Unit

This unit sits between a plain register bus and a slow timekeeping core. Writes aimed at the core's synchronised registers are not applied straight away. The time, alarm, stopwatch, prescaler-enable and interrupt-mask registers are each written through one shared shadow stage. The write waits there until the next count tick, and only then is it committed to the core. While a write waits, a pending flag is raised. When the write lands, a write-complete status bit is set, and that bit can raise the interrupt.

The shadow stage holds a single entry. A second synchronised write that arrives before the first has committed is discarded. The event status register is the exception to the delay: writing ones to it clears the matching bits at once, and such a write never sets the pending flag.

The tick that drives commits is chosen by the committed prescaler-enable bit. When the bit is 1, commits follow the divided one-per-second strobe. When it is 0, they follow the raw oscillator strobe. Both strobes arrive as single-cycle pulses in the bus clock domain.

Top module: `rtsync_write_unit`

## Requirements
- R1: After reset no write is pending, the write-complete bit is clear, all committed registers read as zero and the interrupt is low.
- R2: A bus write to a synchronised address (0 time, 1 alarm, 2 stopwatch, 3 prescaler enable, 4 interrupt mask), made while nothing is pending, is captured into the shadow stage. From the next cycle it reads as status bit 14 = 1, and `pending_o` is high. The committed value does not change.
- R3: A pending write commits in the cycle in which the selected tick strobe is high. In that cycle the matching bit of `commit_o` pulses (bit n for address n), the committed register takes the shadow data at that clock edge, and the pending flag is clear from the next cycle.
- R4: A synchronised write that arrives while a write is pending is dropped without effect. This holds even when it arrives in the same cycle as the commit of the earlier write.
- R5: Status bit 15 (write complete) sets on every commit. It is cleared by writing 1 to bit 15 of the status register at address 5. If a commit and a clear fall in the same cycle, the set wins.
- R6: `irq_o` is high when status bit 15 and interrupt-mask bit 15 are both 1, or when any event bit n (n in 0..13) and mask bit n are both 1.
- R7: Event bits 13:0 of the status register are set by `event_set_i`. They are cleared by writing ones to them at address 5, and a same-cycle set wins. A status write takes effect in the next cycle and never raises the pending flag.
- R8: While the committed prescaler-enable bit is 0, commits occur only on `tick_raw_i`. While it is 1, commits occur only on `tick_sec_i`.
- R9: A read returns the committed value and never the pending shadow value. Committed registers hold only their width: 32 bits for time and alarm, 16 for stopwatch and mask, 1 for prescaler enable. Upper bits read as zero.
- R10: Writes to the unused addresses 6 and 7 have no effect, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| tick_raw_i | input | 1 | Raw oscillator tick strobe |
| tick_sec_i | input | 1 | Divided one-per-second tick strobe |
| event_set_i | input | 14 | Event bits raised by the core |
| commit_o | output | 5 | One-cycle commit strobe per synchronised register |
| time_o | output | 32 | Committed time value |
| alarm_o | output | 32 | Committed alarm value |
| swatch_o | output | 16 | Committed stopwatch value |
| pren_o | output | 1 | Committed prescaler enable |
| imask_o | output | 16 | Committed interrupt mask |
| pending_o | output | 1 | Synchronised write waiting for a tick |
| complete_o | output | 1 | Write-complete status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 3-bit address. This puts every synchronised register, the status register and both unused addresses within reach of the random stimulus. The one-bit and 16-bit committed widths make the truncation of wide writes visible. Because the prescaler bit itself goes through the shadow stage, random traffic flips the active tick source over the run. This exercises commits on both strobes, drops in the same cycle as a commit, and complete-bit set/clear collisions.

// File: rtl/rtsync_pkg.sv
package rtsync_pkg;
  localparam int DW     = 32;
  localparam int AW     = 3;
  localparam int NSYNC  = 5;
  localparam int STAT_W = 16;
  localparam int EV_W   = STAT_W - 2;
  localparam int TIME_W = 32;
  localparam int SW_W   = 16;
  localparam int MASK_W = 16;
  localparam int PREN_W = 1;

  typedef enum logic [AW-1:0] {
    A_TIME   = 3'd0,
    A_ALARM  = 3'd1,
    A_SWATCH = 3'd2,
    A_PREN   = 3'd3,
    A_MASK   = 3'd4,
    A_STAT   = 3'd5
  } reg_addr_e;

  function automatic int sync_width(int idx);
    case (idx)
      0, 1:    return TIME_W;
      2:       return SW_W;
      3:       return PREN_W;
      default: return MASK_W;
    endcase
  endfunction

  function automatic logic [DW-1:0] sync_mask(int idx);
    logic [63:0] m;
    m = (64'd1 << sync_width(idx)) - 64'd1;
    return m[DW-1:0];
  endfunction
endpackage

// File: rtl/rtsync_shadow.sv
module rtsync_shadow #(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [IW-1:0] cap_idx_i,
  input  logic [DW-1:0] cap_data_i,
  input  logic          tick_i,
  output logic          pending_o,
  output logic          commit_o,
  output logic [IW-1:0] commit_idx_o,
  output logic [DW-1:0] commit_data_o
);
  logic          pend_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] data_q;

  assign pending_o     = pend_q;
  assign commit_o      = pend_q & tick_i;
  assign commit_idx_o  = idx_q;
  assign commit_data_o = data_q;

  // a capture is only taken while empty, so a write in the commit cycle is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else if (commit_o) begin
      pend_q <= 1'b0;
    end else if (cap_i && !pend_q) begin
      pend_q <= 1'b1;
      idx_q  <= cap_idx_i;
      data_q <= cap_data_i;
    end
  end
endmodule

// File: rtl/rtsync_commit_regs.sv
module rtsync_commit_regs
  import rtsync_pkg::*;
#(
  parameter int N  = NSYNC,
  parameter int W  = DW,
  parameter int IW = AW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  logic [IW-1:0]       idx_i,
  input  logic [W-1:0]        data_i,
  output logic [N-1:0]        strobe_o,
  output logic [N-1:0][W-1:0] regs_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    localparam logic [W-1:0] MSK = W'(sync_mask(g));
    logic [W-1:0] q;

    assign strobe_o[g] = commit_i && (idx_i == IW'(g));
    assign regs_o[g]   = q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (strobe_o[g]) q <= data_i & MSK;
    end
  end
endmodule

// File: rtl/rtsync_status.sv
module rtsync_status #(
  parameter int STAT_W = 16,
  localparam int EV_W  = STAT_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  input  logic [EV_W-1:0]   ev_set_i,
  input  logic              pending_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              done_o,
  output logic              irq_o
);
  logic            done_q;
  logic [EV_W-1:0] ev_q;
  logic [EV_W-1:0] ev_clr;

  assign ev_clr = clr_wr_i ? clr_data_i[EV_W-1:0] : '0;

  // set beats clear on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ev_q   <= '0;
    end else begin
      done_q <= commit_i | (done_q & ~(clr_wr_i & clr_data_i[STAT_W-1]));
      ev_q   <= (ev_q & ~ev_clr) | ev_set_i;
    end
  end

  assign stat_o = {done_q, pending_i, ev_q};
  assign done_o = done_q;
  assign irq_o  = (done_q & mask_i[STAT_W-1]) | (|(ev_q & mask_i[EV_W-1:0]));
endmodule

// File: rtl/rtsync_write_unit.sv
module rtsync_write_unit
  import rtsync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              tick_raw_i,
  input  logic              tick_sec_i,
  input  logic [EV_W-1:0]   event_set_i,
  output logic [NSYNC-1:0]  commit_o,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] alarm_o,
  output logic [SW_W-1:0]   swatch_o,
  output logic              pren_o,
  output logic [MASK_W-1:0] imask_o,
  output logic              pending_o,
  output logic              complete_o,
  output logic              irq_o
);
  logic                     is_sync, is_stat, tick_sel;
  logic                     commit_any;
  logic [AW-1:0]            commit_idx;
  logic [DW-1:0]            commit_data;
  logic [NSYNC-1:0][DW-1:0] regs;
  logic [STAT_W-1:0]        stat;

  assign is_sync  = wr_en_i && (wr_addr_i < AW'(NSYNC));
  assign is_stat  = wr_en_i && (wr_addr_i == A_STAT);
  assign tick_sel = pren_o ? tick_sec_i : tick_raw_i;

  rtsync_shadow #(.DW(DW), .IW(AW)) u_shadow (
    .clk_i, .rst_ni,
    .cap_i        (is_sync),
    .cap_idx_i    (wr_addr_i),
    .cap_data_i   (wr_data_i),
    .tick_i       (tick_sel),
    .pending_o    (pending_o),
    .commit_o     (commit_any),
    .commit_idx_o (commit_idx),
    .commit_data_o(commit_data)
  );

  rtsync_commit_regs #(.N(NSYNC), .W(DW), .IW(AW)) u_regs (
    .clk_i, .rst_ni,
    .commit_i(commit_any),
    .idx_i   (commit_idx),
    .data_i  (commit_data),
    .strobe_o(commit_o),
    .regs_o  (regs)
  );

  assign time_o   = regs[A_TIME][TIME_W-1:0];
  assign alarm_o  = regs[A_ALARM][TIME_W-1:0];
  assign swatch_o = regs[A_SWATCH][SW_W-1:0];
  assign pren_o   = regs[A_PREN][0];
  assign imask_o  = regs[A_MASK][MASK_W-1:0];

  rtsync_status #(.STAT_W(STAT_W)) u_stat (
    .clk_i, .rst_ni,
    .commit_i  (commit_any),
    .clr_wr_i  (is_stat),
    .clr_data_i(wr_data_i[STAT_W-1:0]),
    .ev_set_i  (event_set_i),
    .pending_i (pending_o),
    .mask_i    (imask_o),
    .stat_o    (stat),
    .done_o    (complete_o),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < AW'(NSYNC))    rd_data_o = regs[rd_addr_i];
    else if (rd_addr_i == A_STAT)  rd_data_o = DW'(stat);
  end
endmodule

// File: rtl/rtsync_write_unit_chk.sv
module rtsync_write_unit_chk
  import rtsync_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic             tick_raw_i,
  input logic             tick_sec_i,
  input logic [NSYNC-1:0] commit_o,
  input logic             pren_o,
  input logic             pending_o,
  input logic             complete_o
);
  // R3
  commit_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(commit_o));
  // R8
  commit_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|commit_o) |-> (pren_o ? tick_sec_i : tick_raw_i));
  // R3
  commit_clears_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|commit_o) |=> !pending_o);
  // R4
  commit_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|commit_o) |-> pending_o);
  // R4
  pend_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o && !(|commit_o)) |=> pending_o);
  // R5
  commit_sets_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|commit_o) |=> complete_o);
  // R2
  pend_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pending_o) |-> $past(wr_en_i && (wr_addr_i < AW'(NSYNC))));
  // R7
  stat_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_STAT && !pending_o) |=> !pending_o);
endmodule

bind rtsync_write_unit rtsync_write_unit_chk u_chk (.*);

// File: tb/rtsync_write_unit_tb_top.sv
module rtsync_write_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYC   = 3000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tick_raw = 1'b0, tick_sec = 1'b0;
  logic [13:0] ev_set = '0;
  logic [31:0] rd_data;
  logic [4:0]  commit;
  logic [31:0] time_v, alarm_v;
  logic [15:0] swatch_v, imask_v;
  logic        pren, pending, complete, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtsync_write_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_raw_i(tick_raw), .tick_sec_i(tick_sec), .event_set_i(ev_set),
    .commit_o(commit), .time_o(time_v), .alarm_o(alarm_v), .swatch_o(swatch_v),
    .pren_o(pren), .imask_o(imask_v), .pending_o(pending),
    .complete_o(complete), .irq_o(irq)
  );

  // reference model state
  logic [31:0] m_reg [5];
  logic        m_pend, m_done;
  logic [2:0]  m_idx;
  logic [31:0] m_data;
  logic [13:0] m_ev;

  function automatic logic [31:0] wmask(int idx);
    case (idx)
      0, 1:    return 32'hFFFF_FFFF;
      2, 4:    return 32'h0000_FFFF;
      default: return 32'h0000_0001;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    if (a < 3'd5)  return m_reg[a];
    if (a == 3'd5) return {16'h0, m_done, m_pend, m_ev};
    return 32'h0;
  endfunction

  function automatic logic exp_irq();
    return (m_done & m_reg[4][15]) | (|(m_ev & m_reg[4][13:0]));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    m_pend = 0; m_done = 0; m_idx = '0; m_data = '0; m_ev = '0;
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic tr, input logic ts, input logic [13:0] ev,
                     input logic [2:0] ra);
    logic sel, cm;
    logic [4:0] exp_cm;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick_raw = tr; tick_sec = ts;
    ev_set = ev; rd_addr = ra;
    #1;
    sel = m_reg[3][0] ? ts : tr;
    cm  = m_pend && sel;
    exp_cm = cm ? (5'b1 << m_idx) : 5'b0;
    chk("R3 commit strobe", 32'(commit), 32'(exp_cm));
    chk("R2 pending", 32'(pending), 32'(m_pend));
    chk("R5 complete", 32'(complete), 32'(m_done));
    chk("R6 irq", 32'(irq), 32'(exp_irq()));
    chk("R9 read data", rd_data, exp_rd(ra));
    @(posedge clk);
    if (cm) m_reg[m_idx] = m_data & wmask(int'(m_idx));
    if (we && a == 3'd5) begin
      m_done = cm | (m_done & ~d[15]);
      m_ev   = (m_ev & ~d[13:0]) | ev;
    end else begin
      m_done = cm | m_done;
      m_ev   = m_ev | ev;
    end
    if (cm) m_pend = 0;
    else if (we && a < 3'd5 && !m_pend) begin
      m_pend = 1; m_idx = a; m_data = d;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, 0, 0, 0, 3'd0);
  endtask

  task automatic after_edge();
    #1;
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pending", 32'(pending), 0);
    chk("R1 complete", 32'(complete), 0);
    chk("R1 time", time_v, 0);
    chk("R1 irq", 32'(irq), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R2 capture, value not yet visible
    cyc(1, 3'd0, 32'h1234_5678, 0, 0, 0, 3'd0); after_edge();
    chk("R2 pending set", 32'(pending), 1);
    chk("R2 time unchanged", time_v, 0);
    // R4 drops while pending
    cyc(1, 3'd0, 32'hDEAD_BEEF, 0, 0, 0, 3'd0);
    cyc(1, 3'd1, 32'h0000_0005, 0, 0, 0, 3'd1);
    // R8 second tick ignored while prescaler disabled
    cyc(0, 3'd0, 0, 0, 1, 0, 3'd0); after_edge();
    chk("R8 sec tick ignored", time_v, 0);
    chk("R8 still pending", 32'(pending), 1);
    // R3 raw tick commits; R4 write in commit cycle dropped
    cyc(1, 3'd1, 32'h0000_0077, 1, 0, 0, 3'd0); after_edge();
    chk("R3 time committed", time_v, 32'h1234_5678);
    chk("R3 pending cleared", 32'(pending), 0);
    chk("R4 alarm untouched", alarm_v, 0);
    chk("R5 complete set", 32'(complete), 1);
    // R5 clear by writing one
    cyc(1, 3'd5, 32'h0000_8000, 0, 0, 0, 3'd5); after_edge();
    chk("R5 complete cleared", 32'(complete), 0);
    // R8 enable prescaler, then commits follow the second tick
    cyc(1, 3'd3, 32'hFFFF_FFFF, 0, 0, 0, 3'd3);
    cyc(0, 3'd0, 0, 1, 0, 0, 3'd3); after_edge();
    chk("R9 pren width", 32'(pren), 1);
    cyc(1, 3'd2, 32'h0001_ABCD, 0, 0, 0, 3'd2);
    cyc(0, 3'd0, 0, 1, 0, 0, 3'd2); after_edge();
    chk("R8 raw tick ignored", 32'(pending), 1);
    cyc(0, 3'd0, 0, 0, 1, 0, 3'd2); after_edge();
    chk("R9 stopwatch width", 32'(swatch_v), 32'h0000_ABCD);
    // R6 mask bit 15 routes complete to irq
    cyc(1, 3'd4, 32'h0000_8000, 0, 0, 0, 3'd4);
    cyc(0, 3'd0, 0, 0, 1, 0, 3'd4); after_edge();
    chk("R6 irq from complete", 32'(irq), 1);
    // R7 events set and cleared at once, no pending
    cyc(0, 3'd0, 0, 0, 0, 14'h0004, 3'd5); after_edge();
    chk("R7 event set", rd_data & 32'h3FFF, 32'h4);
    cyc(1, 3'd5, 32'h0000_0004, 0, 0, 0, 3'd5); after_edge();
    chk("R7 event cleared", rd_data & 32'h3FFF, 0);
    chk("R7 no pending", 32'(pending), 0);
    // R10 unused address
    cyc(1, 3'd6, 32'hFFFF_FFFF, 0, 0, 0, 3'd6); after_edge();
    chk("R10 no pending", 32'(pending), 0);
    chk("R10 read zero", rd_data, 0);
    // R5 set wins over same-cycle clear
    cyc(1, 3'd1, 32'h0000_0099, 0, 0, 0, 3'd1);
    cyc(1, 3'd5, 32'h0000_8000, 0, 1, 0, 3'd1); after_edge();
    chk("R5 set wins", 32'(complete), 1);
    chk("R3 alarm committed", alarm_v, 32'h99);

    // constrained random traffic against the model
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < RAND_CYC; i++) begin
      logic we, tr, ts;
      logic [2:0] a, ra;
      logic [31:0] d;
      logic [13:0] ev;
      we = ($urandom % 10) < 3;
      a  = 3'($urandom % 8);
      d  = $urandom;
      tr = ($urandom % 5) == 0;
      ts = ($urandom % 20) == 0;
      ev = (($urandom % 8) == 0) ? 14'($urandom) : 14'h0;
      ra = 3'($urandom % 8);
      cyc(we, a, d, tr, ts, ev, ra);
    end
    idle(2);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule